// File: doc/BRIEF.md
# Iterative Round-Robin Crossbar Matcher

This block computes a one-to-one pairing of inputs and outputs for an N by N input-queued crossbar once per time slot. The line logic presents a request matrix, one bit for each input and output pair that has at least one queued cell, and pulses `start_i`. The block then runs a number of request, grant and accept iterations, one per clock cycle. It signals completion with a one-cycle `done_o` pulse, and the resulting pairing is then readable on `match_o`.

Each output keeps a grant pointer and each input keeps an accept pointer. Both persist from slot to slot and give round-robin fairness. A pointer moves only when its grant is accepted, and only in the first iteration of a slot. Later iterations can only add pairs among ports that are still free. The slot ends after the configured number of iterations, or sooner when an iteration adds nothing.

Top module: `rr_match_sched`

## Requirements
- R1: Synchronous active-low reset clears the match matrix and `done_o`, and sets every grant and accept pointer to zero.
- R2: `start_i` sampled high while idle captures `req_i` and clears the match. Bit i*N+j of `req_i` and `match_o` means input i to output j. Iteration t of the slot is registered t clock edges after the start edge.
- R3: In each iteration, every free output that has requests from free inputs grants the first requesting input at or after its grant pointer, searching upward modulo N.
- R4: Every free input that receives grants accepts the first granting output at or after its accept pointer, searching upward modulo N.
- R5: An output's grant pointer becomes (granted input + 1) mod N only when that grant is accepted in the first iteration. Otherwise it is unchanged.
- R6: An input's accept pointer becomes (accepted output + 1) mod N only when that acceptance happens in the first iteration. Otherwise it is unchanged.
- R7: Pairs found in earlier iterations are kept, and later iterations only add pairs between ports still unmatched. Every input and every output appears in at most one pair.
- R8: `done_o` is a single-cycle pulse registered with the last iteration. That is iteration ITERS, or the first iteration that adds no pair if that comes earlier.
- R9: `start_i` asserted while a slot is still iterating is ignored. The captured requests and the result are unchanged.
- R10: After `done_o`, `match_o` holds its value until the next accepted `start_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a slot with the requests on `req_i` |
| req_i | input | N*N | Request matrix, bit i*N+j = input i has a cell for output j |
| done_o | output | 1 | One-cycle pulse: matching complete |
| match_o | output | N*N | Match matrix, bit i*N+j = input i paired with output j |

## Verification
The bench keeps an arithmetic model of both pointer sets and compares the pairing and the iteration count of every slot, over directed patterns and a long pseudo-random sweep of sparse and dense matrices. A design that moved pointers on grants that were not accepted, or in later iterations, diverges from the model within a few slots. With a full matrix from reset, the result must be the diagonal after exactly four iterations; a design that dropped earlier pairs or let matched ports bid again breaks that. An all-zero matrix must finish after one iteration, which catches a missing early stop. A start pulse during a running slot must not disturb the result, and the result must stay on the outputs after done.

// File: rtl/rrm_pkg.sv
// Shared definitions for the round-robin crossbar matcher.
// Assumes: pointer values are always below the port count passed in.
package rrm_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } rrm_state_e;

    // Advance a round-robin position by one, wrapping at n.
    function automatic int wrap_inc(input int v, input int n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/rrm_rr_pick.sv
// Round-robin picker: returns a one-hot mark of the first set bit of vec
// found at or after position ptr, searching upward and wrapping at N.
// Assumes: ptr < N. An all-zero vec gives an all-zero result.
module rrm_rr_pick #(
    parameter int N  = 4,
    parameter int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    input  logic [PW-1:0] ptr,
    output logic [N-1:0]  pick_oh
);

    // Scan N positions starting at the pointer; the first hit wins.
    always_comb begin
        logic found;
        found   = 1'b0;
        pick_oh = '0;
        for (int k = 0; k < N; k++) begin
            int pos;
            pos = (int'(ptr) + k) % N;
            if (!found && vec[pos]) begin
                found        = 1'b1;
                pick_oh[pos] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rrm_grant_stage.sv
// Grant phase: each output that is still free chooses one free requesting
// input, using its own grant pointer. gnt[j][i] = output j grants input i.
// Assumes: busy flags describe pairs already fixed in this slot.
module rrm_grant_stage #(
    parameter int N  = 4,
    parameter int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0][N-1:0]  req_m,
    input  logic [N-1:0]         in_busy,
    input  logic [N-1:0]         out_busy,
    input  logic [N-1:0][PW-1:0] gptr,
    output logic [N-1:0][N-1:0]  gnt
);

    for (genvar j = 0; j < N; j++) begin : g_out
        logic [N-1:0] elig;

        // Collect the free inputs that ask for this output, if it is free.
        always_comb begin
            for (int i = 0; i < N; i++) begin
                elig[i] = req_m[i][j] & ~in_busy[i] & ~out_busy[j];
            end
        end

        rrm_rr_pick #(.N(N), .PW(PW)) u_pick (
            .vec     (elig),
            .ptr     (gptr[j]),
            .pick_oh (gnt[j])
        );
    end

endmodule

// File: rtl/rrm_accept_stage.sv
// Accept phase: each input chooses one of the outputs that granted it,
// using its own accept pointer. acc[i][j] = input i accepts output j.
// Assumes: grants only reach inputs that are still free.
module rrm_accept_stage #(
    parameter int N  = 4,
    parameter int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0][N-1:0]  gnt,
    input  logic [N-1:0][PW-1:0] aptr,
    output logic [N-1:0][N-1:0]  acc
);

    for (genvar i = 0; i < N; i++) begin : g_in
        logic [N-1:0] offers;

        // Gather the grants addressed to this input from every output.
        always_comb begin
            for (int j = 0; j < N; j++) begin
                offers[j] = gnt[j][i];
            end
        end

        rrm_rr_pick #(.N(N), .PW(PW)) u_pick (
            .vec     (offers),
            .ptr     (aptr[i]),
            .pick_oh (acc[i])
        );
    end

    // At most one grant accepted per input (R7).
    for (genvar i = 0; i < N; i++) begin : g_chk
        always_comb begin
            assert ($onehot0(acc[i]) || $isunknown(acc[i]));
        end
    end

endmodule

// File: rtl/rr_match_sched.sv
// Iterative round-robin crossbar matcher. A start pulse captures the
// request matrix; one request/grant/accept iteration then runs per cycle
// until ITERS iterations are done or an iteration adds no pair, and done
// pulses with the final result. Pointers persist across slots and move
// only on pairs formed in the first iteration.
// Assumes: req_i is sampled only on the accepted start edge.
module rr_match_sched #(
    parameter int N     = 4,
    parameter int ITERS = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [N*N-1:0] req_i,
    output logic           done_o,
    output logic [N*N-1:0] match_o
);
    import rrm_pkg::*;

    localparam int PW = (N > 1) ? $clog2(N) : 1;
    localparam int IW = (ITERS > 1) ? $clog2(ITERS + 1) : 1;

    rrm_state_e            state_q;
    logic [IW-1:0]         iter_q;
    logic [N-1:0][N-1:0]   req_q;
    logic [N-1:0][N-1:0]   match_q;
    logic                  done_q;
    logic [N-1:0][PW-1:0]  gptr_q;
    logic [N-1:0][PW-1:0]  aptr_q;

    logic [N-1:0]          in_busy;
    logic [N-1:0]          out_busy;
    logic [N-1:0][N-1:0]   gnt;
    logic [N-1:0][N-1:0]   acc;
    logic                  running;
    logic                  first_iter;
    logic                  last_iter;

    assign running    = (state_q == ST_RUN);
    assign first_iter = running && (iter_q == '0);
    assign last_iter  = (acc == '0) || (iter_q == IW'(ITERS - 1));

    // Derive which ports are already taken by the pairs fixed so far.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            in_busy[i] = |match_q[i];
        end
        for (int j = 0; j < N; j++) begin
            out_busy[j] = 1'b0;
            for (int i = 0; i < N; i++) begin
                out_busy[j] = out_busy[j] | match_q[i][j];
            end
        end
    end

    rrm_grant_stage #(.N(N), .PW(PW)) u_grant (
        .req_m    (req_q),
        .in_busy  (in_busy),
        .out_busy (out_busy),
        .gptr     (gptr_q),
        .gnt      (gnt)
    );

    rrm_accept_stage #(.N(N), .PW(PW)) u_accept (
        .gnt  (gnt),
        .aptr (aptr_q),
        .acc  (acc)
    );

    // Slot sequencing: capture on start, add one iteration per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            iter_q  <= '0;
            req_q   <= '0;
            match_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!running) begin
                if (start_i) begin
                    for (int i = 0; i < N; i++) begin
                        for (int j = 0; j < N; j++) begin
                            req_q[i][j] <= req_i[i*N + j];
                        end
                    end
                    match_q <= '0;
                    iter_q  <= '0;
                    state_q <= ST_RUN;
                end
            end else begin
                match_q <= match_q | acc;
                iter_q  <= iter_q + 1'b1;
                if (last_iter) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    // Pointer update: only pairs formed in the first iteration move pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gptr_q <= '0;
            aptr_q <= '0;
        end else if (first_iter) begin
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin
                    if (acc[i][j]) begin
                        aptr_q[i] <= PW'(wrap_inc(j, N));
                        gptr_q[j] <= PW'(wrap_inc(i, N));
                    end
                end
            end
        end
    end

    // Flatten the match matrix onto the output port.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                match_o[i*N + j] = match_q[i][j];
            end
        end
    end

    assign done_o = done_q;

    // Pairs are never removed while a slot runs (R7).
    p_keep_pairs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> ((match_q & $past(match_q)) == $past(match_q)));

    // Pointers hold outside the first iteration (R5, R6).
    p_gptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !first_iter |=> $stable(gptr_q));
    p_aptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !first_iter |=> $stable(aptr_q));

    // Done lasts a single cycle (R8).
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // A start during a running slot does not recapture requests (R9).
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && start_i) |=> $stable(req_q));

    // Result holds while idle without a new start (R10).
    p_hold_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start_i) |=> $stable(match_q));

    // Every input and output sits in at most one pair (R7).
    for (genvar i = 0; i < N; i++) begin : g_row_chk
        p_row_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(match_q[i]));
    end
    for (genvar j = 0; j < N; j++) begin : g_col_chk
        logic [N-1:0] col;
        always_comb begin
            for (int i = 0; i < N; i++) begin
                col[i] = match_q[i][j];
            end
        end
        p_col_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col));
    end

endmodule

// File: tb/rr_match_sched_test.sv
`timescale 1ns/1ps
module rr_match_sched_test;
    localparam int N     = 4;
    localparam int ITERS = 4;
    localparam int NN    = N * N;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NN-1:0] req = '0;
    logic          done;
    logic [NN-1:0] match;

    int n_chk = 0;
    int n_bad = 0;
    int gp [N];
    int ap [N];
    logic [31:0] lfsr = 32'h1BADC0DE;

    always #10 clk = ~clk;

    rr_match_sched #(.N(N), .ITERS(ITERS)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .req_i   (req),
        .done_o  (done),
        .match_o (match)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference pairing from the requirement text, with its own pointers.
    task automatic model_slot(input logic [NN-1:0] r, output logic [NN-1:0] m, output int its);
        logic stop;
        m = '0; its = 0; stop = 1'b0;
        for (int t = 0; t < ITERS; t++) begin
            if (!stop) begin
                int g [N];
                int a [N];
                logic ib [N];
                logic ob [N];
                int added;
                its++;
                for (int x = 0; x < N; x++) begin
                    ib[x] = 1'b0; ob[x] = 1'b0; g[x] = -1; a[x] = -1;
                end
                for (int i = 0; i < N; i++)
                    for (int j = 0; j < N; j++)
                        if (m[i*N+j]) begin ib[i] = 1'b1; ob[j] = 1'b1; end
                for (int j = 0; j < N; j++)
                    if (!ob[j])
                        for (int k = 0; k < N; k++) begin
                            int i;
                            i = (gp[j] + k) % N;
                            if (g[j] < 0 && !ib[i] && r[i*N+j]) g[j] = i;
                        end
                for (int i = 0; i < N; i++)
                    if (!ib[i])
                        for (int k = 0; k < N; k++) begin
                            int j;
                            j = (ap[i] + k) % N;
                            if (a[i] < 0 && g[j] == i) a[i] = j;
                        end
                added = 0;
                for (int i = 0; i < N; i++)
                    if (a[i] >= 0) begin
                        m[i*N + a[i]] = 1'b1;
                        added++;
                        if (its == 1) begin
                            ap[i] = (a[i] + 1) % N;
                            gp[a[i]] = (i + 1) % N;
                        end
                    end
                if (added == 0) stop = 1'b1;
            end
        end
    endtask

    // One slot: start, count cycles to done, compare result and hold.
    task automatic run_slot(input logic [NN-1:0] r, input string tag, input int intr,
                            input logic [NN-1:0] alt);
        logic [NN-1:0] exp_m;
        logic [NN-1:0] held;
        int exp_it;
        int cnt;
        model_slot(r, exp_m, exp_it);
        @(negedge clk);
        req = r; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        while (cnt < 3 * ITERS && !(cnt > 0 && done)) begin
            @(posedge clk);
            @(negedge clk);
            cnt++;
            if (cnt == intr) begin start = 1'b1; req = alt; end
            else start = 1'b0;
        end
        start = 1'b0;
        // R2 R8: done arrives with the last iteration.
        check(cnt == exp_it, {tag, " R2 R8 iterations"}, cnt, exp_it);
        check(match == exp_m, {tag, " match"}, int'(match), int'(exp_m));
        held = match;
        repeat (3) @(negedge clk);
        // R10: result held, done back low.
        check(match == held && !done, {tag, " R10 hold"}, int'(match), int'(held));
    endtask

    initial begin
        for (int x = 0; x < N; x++) begin gp[x] = 0; ap[x] = 0; end
        repeat (3) @(negedge clk);
        // R1: reset state.
        check(match == '0 && !done, "R1 reset", int'(match), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(match == '0 && !done, "R1 after release", int'(match), 0);

        // R1 R7: zero pointers and full requests give the diagonal.
        run_slot('1, "R1 R7 full", 0, '0);
        check(match == 16'h8421, "R7 diagonal", int'(match), 16'h8421);
        // R9: a start mid-slot is ignored.
        run_slot('1, "R9 start while busy", 2, 16'h0001);
        // R8: empty matrix ends after one iteration.
        run_slot('0, "R8 empty", 0, '0);
        // R5: two inputs contend for output 0; grant pointer rotates.
        run_slot(16'h0011, "R5 grant rotate a", 0, '0);
        run_slot(16'h0011, "R5 grant rotate b", 0, '0);
        run_slot(16'h0011, "R5 grant rotate c", 0, '0);
        // R6: one input offered two outputs; accept pointer rotates.
        run_slot(16'h0003, "R6 accept rotate a", 0, '0);
        run_slot(16'h0003, "R6 accept rotate b", 0, '0);
        run_slot(16'h1248, "R3 R4 antidiag", 0, '0);
        // R3 R4 R5 R6 R7: pseudo-random sweep of sparse, mixed and dense matrices.
        for (int s = 0; s < 400; s++) begin
            logic [NN-1:0] r;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            case (s % 3)
                0: r = lfsr[15:0] & lfsr[31:16];
                1: r = lfsr[15:0];
                default: r = lfsr[15:0] | lfsr[31:16];
            endcase
            run_slot(r, "R3 R4 R5 R6 R7 sweep", 0, '0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule